// File: doc/BRIEF.md
# Mirrored Double-Buffered Polyphase Coefficient Store

This block holds the polyphase filter coefficients for a two-dimensional video scaler. It has four filter kinds: luma vertical, chroma vertical, luma horizontal and chroma horizontal. The phase table has 64 phases, and the coefficients are symmetric across phases. Only phases 0 to 32 are stored. A read of any higher phase folds back onto a stored phase and returns that phase's taps in reverse order.

Programming works like a register pair. A select write latches the filter kind, the phase and the tap-pair index. Each data write that follows loads one even/odd coefficient pair, and each half of the pair has its own enable. Data writes always land in a shadow bank. The bank that the scaler's read port sees changes only when software raises an update-done strobe and the next frame-start pulse arrives.

Coefficient memory is normally power gated. Software must request that gating be disabled and wait for the memory state output to read zero. A data write made without that acknowledgement is discarded and raises a sticky error.

Top module: `coef_mirror_ram`

## Requirements
- R1: After reset, every stored coefficient in both banks reads zero, `pg_state` is 1 (gated), and `wr_err` and `upd_pend` are 0.
- R2: While `pg_dis_req` stays high, `pg_state` falls to 0 after PWR_LAT rising edges. The edge after `pg_dis_req` goes low returns `pg_state` to 1.
- R3: A data write is accepted only when `pg_dis_req` is 1 and `pg_state` is 0. Any other data write is discarded and sets `wr_err`, which stays set until reset.
- R4: `sel_we` latches `sel_kind`, `sel_phase` and `sel_pair`, and later data writes use the latched values. The kind encoding is 0 luma vertical, 1 chroma vertical, 2 luma horizontal, 3 chroma horizontal.
- R5: A data write to pair k stores `even_coef` in tap 2k if `even_en` is 1, and stores `odd_coef` in tap 2k+1 if `odd_en` is 1. A half whose enable is 0 keeps its old value.
- R6: Data writes go only to the shadow bank, so reads of the active bank do not change until a swap. After a swap, the former active bank becomes the new shadow.
- R7: `upd_done` sets `upd_pend`. On the first `frame_start` edge with `upd_pend` set, the banks swap and `upd_pend` clears. A `frame_start` without `upd_pend` swaps nothing.
- R8: A read returns its result on `rd_coefs` one clock after `rd_kind` and `rd_phase` are presented. Tap k is at bits [k*COEF_W +: COEF_W].
- R9: A read of phase p ≤ 32 returns the stored phase p. A read of p > 32 returns stored phase 64−p with tap k taken from tap MAX_TAPS−1−k.
- R10: A data write whose latched phase is above 32 is discarded and does not set `wr_err`.
- R11: Each filter kind keeps its own storage, so a write to one kind leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | 1 | Latch select fields |
| sel_kind | input | 2 | Filter kind to program |
| sel_phase | input | PH_W (6) | Phase to program |
| sel_pair | input | PAIR_W (1) | Tap-pair index to program |
| dat_we | input | 1 | Coefficient pair write |
| even_en | input | 1 | Enable for even tap |
| even_coef | input | COEF_W (14) | Even tap coefficient |
| odd_en | input | 1 | Enable for odd tap |
| odd_coef | input | COEF_W (14) | Odd tap coefficient |
| pg_dis_req | input | 1 | Power-gate disable request |
| pg_state | output | 1 | Memory power state, 0 means ungated |
| upd_done | input | 1 | Update-complete strobe |
| frame_start | input | 1 | Frame boundary pulse |
| upd_pend | output | 1 | Swap waiting for frame start |
| wr_err | output | 1 | Sticky dropped-write flag |
| rd_kind | input | 2 | Filter kind to read |
| rd_phase | input | PH_W (6) | Phase to read, 0..63 |
| rd_coefs | output | MAX_TAPS*COEF_W (56) | All taps of the read phase |

## Verification
The checker watches the control state on every cycle. It checks that the gate returns to 1 when the request drops, that a write without acknowledgement raises the error and the error never clears, that the update strobe raises the pending flag, and that the active bank changes only on a frame start with an update pending. The bench scenarios cover the data behaviour. They show per-half write enables, shadow isolation before a swap, ping-pong loss of old contents after a swap, mirrored and reversed reads above phase 32, discarded high-phase writes, and separation between filter kinds.

// File: rtl/coef_ram_pkg.sv
// Shared types for the mirrored coefficient store.
package coef_ram_pkg;
    // Filter kind codes; the numeric values are visible at the ports.
    typedef enum logic [1:0] {
        FK_LUMA_V   = 2'd0,
        FK_CHROMA_V = 2'd1,
        FK_LUMA_H   = 2'd2,
        FK_CHROMA_H = 2'd3
    } filt_kind_e;
endpackage

// File: rtl/coef_pwr_gate.sv
// Memory power-gate model: the gate state drops to 0 (ungated) after
// PWR_LAT cycles of a held disable request and goes back to 1 one cycle
// after the request is released. Assumes PWR_LAT >= 1.
module coef_pwr_gate #(
    parameter int PWR_LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dis_req,
    output logic mem_state,
    output logic wr_ok
);
    localparam int CNT_W = $clog2(PWR_LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PWR_LAT - 1);

    logic [CNT_W-1:0] cnt;

    // Count toward the ungated state while requested; regate on release.
    always_ff @(posedge clk) begin
        if (!rst_n || !dis_req) begin
            cnt       <= '0;
            mem_state <= 1'b1;
        end else if (cnt == LAST) begin
            mem_state <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Writes are legal only with the request held and the gate open.
    always_comb wr_ok = dis_req && !mem_state;
endmodule

// File: rtl/coef_bank_ctl.sv
// Shadow/active bank selector: an update strobe arms a pending flag, and
// the next frame start flips the active bank and clears the flag.
module coef_bank_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_done,
    input  logic frame_start,
    output logic upd_pend,
    output logic act_bank
);
    // Pending flag and bank flip; a new strobe on the swap edge re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pend <= 1'b0;
            act_bank <= 1'b0;
        end else begin
            if (frame_start && upd_pend) act_bank <= ~act_bank;
            if (upd_done)                upd_pend <= 1'b1;
            else if (frame_start)        upd_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/coef_store.sv
// Two-bank coefficient array holding PHASES/2+1 phases per filter kind.
// Reads fold the upper half of the phase range back onto stored phases
// with the taps reversed; the read result is registered.
// Assumes MAX_TAPS is even and at least 4.
module coef_store #(
    parameter int COEF_W   = 14,
    parameter int MAX_TAPS = 4,
    parameter int PHASES   = 64,
    parameter int KINDS    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_bank,
    input  logic [$clog2(KINDS)-1:0]     wr_kind,
    input  logic [$clog2(PHASES)-1:0]    wr_phase,
    input  logic [$clog2(MAX_TAPS)-2:0]  wr_pair,
    input  logic                         even_en,
    input  logic [COEF_W-1:0]            even_coef,
    input  logic                         odd_en,
    input  logic [COEF_W-1:0]            odd_coef,
    input  logic                         rd_bank,
    input  logic [$clog2(KINDS)-1:0]     rd_kind,
    input  logic [$clog2(PHASES)-1:0]    rd_phase,
    output logic [MAX_TAPS*COEF_W-1:0]   rd_coefs
);
    localparam int HALF   = PHASES / 2;
    localparam int STORED = HALF + 1;
    localparam int PH_W   = $clog2(PHASES);
    localparam int TAP_W  = $clog2(MAX_TAPS);

    logic [COEF_W-1:0] mem [2][KINDS][STORED][MAX_TAPS];
    logic [PH_W:0]     fold_wide;
    logic [PH_W-1:0]   rd_idx;
    logic              rd_fold;
    logic [MAX_TAPS*COEF_W-1:0] rd_next;
    logic [TAP_W-1:0]  even_idx, odd_idx;

    // Fold the requested phase onto the stored half of the table.
    always_comb begin
        rd_fold   = rd_phase > PH_W'(HALF);
        fold_wide = (PH_W+1)'(PHASES) - {1'b0, rd_phase};
        rd_idx    = rd_fold ? fold_wide[PH_W-1:0] : rd_phase;
        even_idx  = {wr_pair, 1'b0};
        odd_idx   = {wr_pair, 1'b1};
    end

    // Assemble taps, reversing the order for mirrored phases.
    for (genvar k = 0; k < MAX_TAPS; k++) begin : g_tap
        always_comb
            rd_next[k*COEF_W +: COEF_W] = rd_fold
                ? mem[rd_bank][rd_kind][rd_idx][MAX_TAPS-1-k]
                : mem[rd_bank][rd_kind][rd_idx][k];
    end

    // Array update with per-half enables and the registered read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < 2; b++)
                for (int t = 0; t < KINDS; t++)
                    for (int p = 0; p < STORED; p++)
                        for (int k = 0; k < MAX_TAPS; k++)
                            mem[b][t][p][k] <= '0;
            rd_coefs <= '0;
        end else begin
            if (wr_en && even_en) mem[wr_bank][wr_kind][wr_phase][even_idx] <= even_coef;
            if (wr_en && odd_en)  mem[wr_bank][wr_kind][wr_phase][odd_idx]  <= odd_coef;
            rd_coefs <= rd_next;
        end
    end
endmodule

// File: rtl/coef_mirror_ram.sv
// Top of the mirrored double-buffered coefficient store: latches the
// programming select, qualifies data writes with the power handshake,
// routes them to the shadow bank and serves reads from the active bank.
module coef_mirror_ram
    import coef_ram_pkg::*;
#(
    parameter int COEF_W   = 14,
    parameter int MAX_TAPS = 4,
    parameter int PHASES   = 64,
    parameter int PWR_LAT  = 4,
    localparam int KINDS   = 4,
    localparam int PH_W    = $clog2(PHASES),
    localparam int PAIR_W  = $clog2(MAX_TAPS) - 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sel_we,
    input  logic [1:0]                 sel_kind,
    input  logic [PH_W-1:0]            sel_phase,
    input  logic [PAIR_W-1:0]          sel_pair,
    input  logic                       dat_we,
    input  logic                       even_en,
    input  logic [COEF_W-1:0]          even_coef,
    input  logic                       odd_en,
    input  logic [COEF_W-1:0]          odd_coef,
    input  logic                       pg_dis_req,
    output logic                       pg_state,
    input  logic                       upd_done,
    input  logic                       frame_start,
    output logic                       upd_pend,
    output logic                       wr_err,
    input  logic [1:0]                 rd_kind,
    input  logic [PH_W-1:0]            rd_phase,
    output logic [MAX_TAPS*COEF_W-1:0] rd_coefs
);
    localparam int HALF = PHASES / 2;

    filt_kind_e        lat_kind;
    logic [PH_W-1:0]   lat_phase;
    logic [PAIR_W-1:0] lat_pair;
    logic              wr_ok, act_bank, wr_en;

    // Hold the programming select until the next select write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_kind  <= FK_LUMA_V;
            lat_phase <= '0;
            lat_pair  <= '0;
        end else if (sel_we) begin
            lat_kind  <= filt_kind_e'(sel_kind);
            lat_phase <= sel_phase;
            lat_pair  <= sel_pair;
        end
    end

    // Flag any data write made without the power acknowledgement.
    always_ff @(posedge clk) begin
        if (!rst_n)                wr_err <= 1'b0;
        else if (dat_we && !wr_ok) wr_err <= 1'b1;
    end

    // Only powered writes to a stored phase reach the array.
    always_comb wr_en = dat_we && wr_ok && (lat_phase <= PH_W'(HALF));

    coef_pwr_gate #(.PWR_LAT(PWR_LAT)) u_pwr (
        .clk       (clk),
        .rst_n     (rst_n),
        .dis_req   (pg_dis_req),
        .mem_state (pg_state),
        .wr_ok     (wr_ok)
    );

    coef_bank_ctl u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_done    (upd_done),
        .frame_start (frame_start),
        .upd_pend    (upd_pend),
        .act_bank    (act_bank)
    );

    coef_store #(
        .COEF_W   (COEF_W),
        .MAX_TAPS (MAX_TAPS),
        .PHASES   (PHASES),
        .KINDS    (KINDS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_bank   (~act_bank),
        .wr_kind   (lat_kind),
        .wr_phase  (lat_phase),
        .wr_pair   (lat_pair),
        .even_en   (even_en),
        .even_coef (even_coef),
        .odd_en    (odd_en),
        .odd_coef  (odd_coef),
        .rd_bank   (act_bank),
        .rd_kind   (rd_kind),
        .rd_phase  (rd_phase),
        .rd_coefs  (rd_coefs)
    );
endmodule

// File: rtl/coef_mirror_ram_chk.sv
// Cycle-level protocol checks for coef_mirror_ram, attached by bind.
module coef_mirror_ram_chk (
    input logic clk,
    input logic rst_n,
    input logic pg_dis_req,
    input logic pg_state,
    input logic dat_we,
    input logic wr_err,
    input logic upd_done,
    input logic frame_start,
    input logic upd_pend,
    input logic act_bank
);
    // R2
    gate_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_dis_req |=> pg_state);

    // R3
    err_on_unpowered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !(pg_dis_req && !pg_state)) |=> wr_err);

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);

    // R7
    pend_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_done |=> upd_pend);

    // R7
    swap_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && upd_pend) |=> (act_bank != $past(act_bank)));

    // R6
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_start && upd_pend) |=> $stable(act_bank));
endmodule

bind coef_mirror_ram coef_mirror_ram_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pg_dis_req  (pg_dis_req),
    .pg_state    (pg_state),
    .dat_we      (dat_we),
    .wr_err      (wr_err),
    .upd_done    (upd_done),
    .frame_start (frame_start),
    .upd_pend    (upd_pend),
    .act_bank    (act_bank)
);

// File: tb/coef_mirror_ram_tb_top.sv
`timescale 1ns/1ps
// Directed bench for coef_mirror_ram: one task per scenario.
module coef_mirror_ram_tb_top;
    localparam int W  = 14;
    localparam int NT = 4;
    localparam int PL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_we = 1'b0, dat_we = 1'b0, even_en = 1'b0, odd_en = 1'b0;
    logic [1:0]    sel_kind = '0, rd_kind = '0;
    logic [5:0]    sel_phase = '0, rd_phase = '0;
    logic [0:0]    sel_pair = '0;
    logic [W-1:0]  even_coef = '0, odd_coef = '0;
    logic          pg_dis_req = 1'b0, upd_done = 1'b0, frame_start = 1'b0;
    logic          pg_state, upd_pend, wr_err;
    logic [NT*W-1:0] rd_coefs;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    coef_mirror_ram dut_i (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_kind(sel_kind),
        .sel_phase(sel_phase), .sel_pair(sel_pair), .dat_we(dat_we),
        .even_en(even_en), .even_coef(even_coef), .odd_en(odd_en),
        .odd_coef(odd_coef), .pg_dis_req(pg_dis_req), .pg_state(pg_state),
        .upd_done(upd_done), .frame_start(frame_start), .upd_pend(upd_pend),
        .wr_err(wr_err), .rd_kind(rd_kind), .rd_phase(rd_phase),
        .rd_coefs(rd_coefs)
    );

    function automatic logic [NT*W-1:0] pack(input int t0, t1, t2, t3);
        return {W'(t3), W'(t2), W'(t1), W'(t0)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [NT*W-1:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_sel(input int kind, phase, pair);
        @(negedge clk);
        sel_we = 1'b1; sel_kind = 2'(kind); sel_phase = 6'(phase); sel_pair = 1'(pair);
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic do_dat(input bit ee, input int ev, input bit oe, input int od);
        @(negedge clk);
        dat_we = 1'b1; even_en = ee; even_coef = W'(ev); odd_en = oe; odd_coef = W'(od);
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic do_read(input int kind, phase, output logic [NT*W-1:0] val);
        @(negedge clk);
        rd_kind = 2'(kind); rd_phase = 6'(phase);
        @(negedge clk);
        val = rd_coefs;
    endtask

    task automatic pulse_upd();
        @(negedge clk); upd_done = 1'b1;
        @(negedge clk); upd_done = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [NT*W-1:0] v;
        apply_reset();
        check(pg_state == 1'b1, "R1 pg_state", NT*W'(pg_state), 1);
        check(wr_err == 1'b0 && upd_pend == 1'b0, "R1 flags", NT*W'({wr_err, upd_pend}), 0);
        do_read(0, 0, v);
        check(v == '0, "R1 array zero", v, '0);
    endtask

    task automatic t_power_handshake();
        @(negedge clk); pg_dis_req = 1'b1;
        repeat (PL - 1) @(negedge clk);
        check(pg_state == 1'b1, "R2 before latency", NT*W'(pg_state), 1);
        @(negedge clk);
        check(pg_state == 1'b0, "R2 after latency", NT*W'(pg_state), 0);
    endtask

    task automatic t_write_and_swap();
        logic [NT*W-1:0] v;
        do_sel(2, 5, 0); do_dat(1, 100, 1, 101);
        do_sel(2, 5, 1); do_dat(1, 102, 1, 103);
        do_read(2, 5, v);
        check(v == '0, "R6 shadow hidden", v, '0);
        pulse_upd();
        check(upd_pend == 1'b1, "R7 pend set", NT*W'(upd_pend), 1);
        do_read(2, 5, v);
        check(v == '0, "R7 no swap before frame", v, '0);
        pulse_frame();
        check(upd_pend == 1'b0, "R7 pend cleared", NT*W'(upd_pend), 0);
        do_read(2, 5, v);
        check(v == pack(100, 101, 102, 103), "R5 R8 R4 pair taps", v, pack(100, 101, 102, 103));
        do_read(2, 59, v);
        check(v == pack(103, 102, 101, 100), "R9 mirrored reversed", v, pack(103, 102, 101, 100));
        do_read(0, 5, v);
        check(v == '0, "R11 other kind untouched", v, '0);
    endtask

    task automatic t_enables_and_drop();
        logic [NT*W-1:0] v;
        do_sel(1, 32, 0);
        do_dat(1, 200, 1, 201);
        do_dat(1, 202, 0, 777);
        do_dat(0, 555, 1, 203);
        do_sel(1, 32, 1);
        do_dat(1, 204, 0, 888);
        do_sel(1, 40, 0);
        do_dat(1, 300, 1, 301);
        check(wr_err == 1'b0, "R10 no error on high phase", NT*W'(wr_err), 0);
        pulse_upd(); pulse_frame();
        do_read(1, 32, v);
        check(v == pack(202, 203, 204, 0), "R5 R9 per-half enables", v, pack(202, 203, 204, 0));
        do_read(1, 24, v);
        check(v == '0, "R10 high phase dropped", v, '0);
        do_read(1, 40, v);
        check(v == '0, "R10 high phase read", v, '0);
        do_read(2, 5, v);
        check(v == '0, "R6 ping-pong bank", v, '0);
        pulse_frame();
        do_read(1, 32, v);
        check(v == pack(202, 203, 204, 0), "R7 frame without pend", v, pack(202, 203, 204, 0));
    endtask

    task automatic t_unpowered_write();
        logic [NT*W-1:0] v;
        @(negedge clk); pg_dis_req = 1'b0;
        @(negedge clk);
        check(pg_state == 1'b1, "R2 regate", NT*W'(pg_state), 1);
        do_sel(3, 1, 0);
        do_dat(1, 400, 1, 401);
        check(wr_err == 1'b1, "R3 error set", NT*W'(wr_err), 1);
        pulse_upd(); pulse_frame();
        do_read(3, 1, v);
        check(v == '0, "R3 write dropped", v, '0);
        repeat (3) @(negedge clk);
        check(wr_err == 1'b1, "R3 error sticky", NT*W'(wr_err), 1);
        apply_reset();
        check(wr_err == 1'b0, "R1 error cleared by reset", NT*W'(wr_err), 0);
    endtask

    initial begin
        t_reset_state();
        t_power_handshake();
        t_write_and_swap();
        t_enables_and_drop();
        t_unpowered_write();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule